// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This controller copies a block of words between one I/O device and memory while the processor carries on with other work. Software writes four settings through a small register port: the transfer direction, the device address, the first memory address and the number of words. It then sets a start bit. For each word the controller waits until the device can take part. It then asks for the shared bus and waits for the grant. It performs one memory access and gives the bus back at once. The processor is therefore held off only for the single cycle in which a word moves, and its context is never disturbed.

The device sits on the controller's local side. Each word crosses the system bus only once, either from the device into memory or from memory to the device. After every word the memory address steps up by one and the remaining count steps down by one. When the count reaches zero the controller raises an interrupt. The interrupt stays high until software writes a clear bit. A length of zero finishes at once, with no bus traffic.

Top module: `dma_steal`

## Requirements
- R1: After reset, bus_req, mem_en, dev_ack and irq are all low.
- R2: The register port decodes cfg_sel as follows. 0 is control: bit 0 starts, bit 1 selects the direction (0 device-to-memory, 1 memory-to-device) and bit 2 clears the interrupt. 1 is the device address, 2 is the first memory address and 3 is the word count. A write takes effect at the clock edge where cfg_we is high.
- R3: bus_req rises only when dev_rdy was high at the clock edge before it rose. Once raised, bus_req stays high until bus_gnt is seen.
- R4: Each bus ownership moves exactly one word. mem_en is high for one cycle, and only while bus_gnt is high. bus_req drops in the next cycle.
- R5: In the device-to-memory direction a transfer cycle has mem_we high, mem_wdata equal to dev_rdata and dev_ack high.
- R6: In the memory-to-device direction a transfer cycle has mem_we low, dev_wdata equal to mem_rdata and dev_ack high.
- R7: A transfer of N words makes exactly N accesses, at addresses base, base+1, …, base+N-1, in that order.
- R8: irq rises in the cycle after the last word's access. It stays high until a control write with bit 2 set, and it is low from the cycle after that write.
- R9: While a transfer is running, a start is ignored, and so is any write to the direction, device address, memory address or count setting. A later start therefore repeats the earlier settings.
- R10: A start with a word count of zero raises irq in the next cycle and never raises bus_req.
- R11: dev_sel always shows the stored device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted to the controller |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_rdata | input | DATA_W | Data read from memory, valid in the access cycle |
| dev_sel | output | DEV_W | Device address |
| dev_rdy | input | 1 | Device has data (device-to-memory) or space (memory-to-device) |
| dev_rdata | input | DATA_W | Data offered by the device |
| dev_wdata | output | DATA_W | Data delivered to the device |
| dev_ack | output | 1 | Word taken from or given to the device |
| irq | output | 1 | Block complete interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit data and addresses, an 8-bit count and a 4-bit device address. The 8-bit count lets one directed run use the largest length, 255 words, from address 0. It also allows a zero length and a single word. Random grant latency and random device readiness shift every request and transfer to different cycles. A poke while busy, followed by a bare restart, shows at the ports whether a locked setting was overwritten.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_DEV,
        ST_REQ,
        ST_XFER
    } dma_state_e;

    // register select values
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DEV  = 2'd1;
    localparam logic [1:0] SEL_BASE = 2'd2;
    localparam logic [1:0] SEL_LEN  = 2'd3;

    // control word bit positions
    localparam int CTL_START = 0;
    localparam int CTL_DIR   = 1;
    localparam int CTL_CLEAR = 2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DEV_W  = 4,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              busy,
    output logic              start,
    output logic              clear,
    output logic              dir,
    output logic [DEV_W-1:0]  dev_addr,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  word_cnt
);

    typedef struct packed {
        logic              dir;
        logic [DEV_W-1:0]  dev;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  len;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic ctrl_wr;

    always_comb begin
        cfg_d   = cfg_q;
        ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
        start   = ctrl_wr && cfg_wdata[CTL_START] && !busy;
        clear   = ctrl_wr && cfg_wdata[CTL_CLEAR];
        if (cfg_we && !busy) begin
            case (cfg_sel)
                SEL_CTRL: cfg_d.dir  = cfg_wdata[CTL_DIR];
                SEL_DEV:  cfg_d.dev  = cfg_wdata[DEV_W-1:0];
                SEL_BASE: cfg_d.base = cfg_wdata[ADDR_W-1:0];
                default:  cfg_d.len  = cfg_wdata[CNT_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dir       = cfg_q.dir;
    assign dev_addr  = cfg_q.dev;
    assign base_addr = cfg_q.base;
    assign word_cnt  = cfg_q.len;

    // R9: settings are frozen while a transfer runs
    p_lock_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_addr) && $stable(word_cnt) && $stable(dir) && $stable(dev_addr));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clear,
    input  logic              dir,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic              dev_rdy,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              bus_req,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_ack,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  CNT_STEP  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  CNT_NONE  = '0;

    typedef struct packed {
        dma_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic done_set;

    always_comb begin
        seq_d    = seq_q;
        done_set = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (word_cnt == CNT_NONE) begin
                        done_set = 1'b1;
                    end else begin
                        seq_d.st   = ST_WAIT_DEV;
                        seq_d.addr = base_addr;
                        seq_d.left = word_cnt;
                    end
                end
            end
            ST_WAIT_DEV: begin
                if (dev_rdy) seq_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (bus_gnt) seq_d.st = ST_XFER;
            end
            default: begin
                seq_d.addr = seq_q.addr + ADDR_STEP;
                seq_d.left = seq_q.left - CNT_STEP;
                if (seq_q.left == CNT_STEP) begin
                    seq_d.st = ST_IDLE;
                    done_set = 1'b1;
                end else begin
                    seq_d.st = ST_WAIT_DEV;
                end
            end
        endcase
        seq_d.done = (seq_q.done && !clear) || done_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.addr <= '0;
            seq_q.left <= '0;
            seq_q.done <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.st != ST_IDLE);
    assign bus_req   = (seq_q.st == ST_REQ) || (seq_q.st == ST_XFER);
    assign mem_en    = (seq_q.st == ST_XFER);
    assign mem_we    = mem_en && !dir;
    assign mem_addr  = seq_q.addr;
    assign mem_wdata = dev_rdata;
    assign dev_wdata = mem_rdata;
    assign dev_ack   = mem_en;
    assign irq       = seq_q.done;

    // R3: a request starts only after the device reported ready
    p_req_after_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(dev_rdy));
    // R3: request is held until granted
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req);
    // R4: access only under grant
    p_access_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> bus_gnt);
    // R4: one word, then the bus is released
    p_one_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en && !bus_req);
    // R8: interrupt holds until cleared
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clear |=> irq);
    // R10: zero length completes without bus traffic
    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (word_cnt == CNT_NONE) |=> irq && !bus_req);

endmodule

// File: rtl/dma_steal.sv
module dma_steal
    import dma_steal_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DEV_W  = 4,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_sel,
    input  logic              dev_rdy,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_ack,
    output logic              irq
);

    logic              busy, start, clear, dir;
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  word_cnt;

    dma_cfg_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .start(start), .clear(clear), .dir(dir),
        .dev_addr(dev_sel), .base_addr(base_addr), .word_cnt(word_cnt)
    );

    dma_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .clear(clear), .dir(dir),
        .base_addr(base_addr), .word_cnt(word_cnt),
        .dev_rdy(dev_rdy), .dev_rdata(dev_rdata),
        .bus_gnt(bus_gnt), .mem_rdata(mem_rdata),
        .busy(busy), .bus_req(bus_req), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .dev_wdata(dev_wdata), .dev_ack(dev_ack), .irq(irq)
    );

endmodule

// File: tb/dma_steal_test.sv
`timescale 1ns/1ps
module dma_steal_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        bus_req, mem_en, mem_we, dev_ack, irq;
    logic        bus_gnt = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;
    logic [3:0]  dev_sel;
    logic        dev_rdy = 1'b0;

    logic [15:0] mem  [256];
    logic [15:0] src  [256];
    logic [15:0] sink [256];
    int          idx = 0;
    logic [15:0] exp_base = 16'd0;
    logic        cur_dir = 1'b0;
    int          words_in_req = 0;
    logic        prev_req = 1'b0;
    logic        req_seen = 1'b0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_rdata = src[idx[7:0]];

    dma_steal uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_sel(dev_sel), .dev_rdy(dev_rdy), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .dev_ack(dev_ack), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] base, input int k);
        return base + 16'(k);
    endfunction

    // Bus, memory and device models plus per-cycle monitors, all mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) begin
                req_seen = 1'b1;
                chk(dev_rdy, "R3 request without device ready", 0, 1);
            end
            if (mem_en) begin
                chk(bus_gnt, "R4 access without grant", 0, 1);
                chk(dev_ack, "R5/R6 dev_ack in transfer cycle", 0, 1);
                chk(mem_addr == exp_addr(exp_base, idx), "R7 address sequence",
                    mem_addr, exp_addr(exp_base, idx));
                chk(mem_we == !cur_dir, "R5/R6 access direction", mem_we, !cur_dir);
                if (!cur_dir) chk(mem_wdata == src[idx[7:0]], "R5 write data", mem_wdata, src[idx[7:0]]);
                else          sink[idx[7:0]] = dev_wdata;
                words_in_req++;
            end
            if (prev_req && !bus_req) begin
                chk(words_in_req == 1, "R4 words per ownership", words_in_req, 1);
                words_in_req = 0;
            end
            prev_req = bus_req;
            if (mem_en && mem_we) mem[mem_addr[7:0]] = mem_wdata;
            if (dev_ack) begin
                idx++;
                dev_rdy = 1'b0;
            end else if (!dev_rdy && ($urandom % 4 == 0)) begin
                dev_rdy = 1'b1;
            end
            bus_gnt = bus_req ? (bus_gnt || ($urandom % 3 == 0)) : 1'b0;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prep(input logic dir, input logic [15:0] base, input int len);
        @(posedge clk);
        idx = 0; exp_base = base; cur_dir = dir; req_seen = 1'b0;
        for (int k = 0; k < 256; k++) begin
            src[k] = 16'($urandom);
            sink[k] = 16'hDEAD;
        end
        for (int k = 0; k < len; k++) mem[exp_addr(base, k) & 16'hFF] = 16'($urandom);
    endtask

    task automatic wait_done(input int len, input logic dir, input logic [15:0] base);
        int n = 0;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(irq, "R8 irq after block", irq, 1);
        chk(idx == len, "R7 word count", idx, len);
        for (int k = 0; k < len; k++) begin
            if (!dir) chk(mem[exp_addr(base, k) & 16'hFF] == src[k], "R5 memory contents",
                          mem[exp_addr(base, k) & 16'hFF], src[k]);
            else      chk(sink[k] == mem[exp_addr(base, k) & 16'hFF], "R6 device contents",
                          sink[k], mem[exp_addr(base, k) & 16'hFF]);
        end
        repeat (3) @(negedge clk);
        chk(irq, "R8 irq held before clear", irq, 1);
        wr(2'd0, 16'h0004);
        chk(!irq, "R8 irq cleared", irq, 0);
    endtask

    task automatic run(input logic dir, input logic [3:0] dev, input logic [15:0] base, input int len);
        prep(dir, base, len);
        wr(2'd1, {12'd0, dev});
        wr(2'd2, base);
        wr(2'd3, 16'(len));
        chk(dev_sel == dev, "R11 device address", dev_sel, dev);
        wr(2'd0, {14'd0, dir, 1'b1});
        wait_done(len, dir, base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 256; k++) mem[k] = 16'd0;
        repeat (3) @(negedge clk);
        chk(!bus_req && !mem_en && !dev_ack && !irq, "R1 reset outputs",
            {bus_req, mem_en, dev_ack, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!irq && !bus_req, "R1 idle after reset", {irq, bus_req}, 0);

        // R10: zero length
        prep(1'b0, 16'd10, 0);
        wr(2'd3, 16'd0);
        wr(2'd0, 16'h0001);
        chk(irq, "R10 zero length irq", irq, 1);
        repeat (4) @(negedge clk);
        chk(!req_seen, "R10 no bus request", req_seen, 0);
        wr(2'd0, 16'h0004);
        chk(!irq, "R8 clear after zero length", irq, 0);

        // single word each way (R2 register decode)
        run(1'b0, 4'd3, 16'd20, 1);
        run(1'b1, 4'd9, 16'd30, 1);
        // longest count from address 0
        run(1'b1, 4'd5, 16'd0, 255);

        // R9: pokes while busy are ignored, restart repeats old settings
        prep(1'b0, 16'd100, 6);
        wr(2'd1, 16'd7);
        wr(2'd2, 16'd100);
        wr(2'd3, 16'd6);
        wr(2'd0, 16'h0001);
        wr(2'd0, 16'h0003);
        wr(2'd2, 16'd140);
        wr(2'd3, 16'd2);
        wr(2'd1, 16'd1);
        chk(dev_sel == 4'd7, "R9 device address locked", dev_sel, 7);
        wait_done(6, 1'b0, 16'd100);
        prep(1'b0, 16'd100, 6);
        wr(2'd0, 16'h0001);
        wait_done(6, 1'b0, 16'd100);

        // random mix
        for (int t = 0; t < 12; t++) begin
            run(1'($urandom), 4'($urandom), 16'($urandom % 200), 1 + int'($urandom % 14));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule